// File: doc/BRIEF.md
# Chaotic Keystream Masker

This block encrypts one 16-bit plaintext word for each chaotic sample it is given. An external chaotic generator supplies two things with each sample: a 16-bit sample word y and a one-bit select b. The sample word comes from the low bits of the chaotic state, and the select is its most significant bit. The block whitens the samples by XOR-ing the current sample word with the two sample words before it. The result is then XOR-ed with the plaintext and with a feedback word. The feedback word is a past ciphertext word, taken from either one or two words back, depending on b.

Plaintext and samples arrive on two separate valid/ready streams. A word is accepted only when both streams are valid and the output register is free, or is being emptied in that same cycle. A stalled output therefore pushes back on both inputs together. The sample history and the ciphertext history advance only when a word is accepted. Reset clears both histories to zero. A receiver that feeds the same sample stream from the same reset state recovers the plaintext with the same equation.

Top module: `keystream_masker`

## Requirements
- R1: After reset, ct_valid is 0 and every history word is zero, so the first accepted word gives ct_data = pt_data XOR smp_word for either value of smp_sel.
- R2: The keystream for an accepted word is z(n) = y(n) XOR y(n-1) XOR y(n-2), where y(n-1) and y(n-2) are the two previously accepted sample words.
- R3: The ciphertext is C(n) = P(n) XOR z(n) XOR Fb(n).
- R4: Fb(n) is C(n-1) when smp_sel is 0 and C(n-2) when smp_sel is 1. C(n-1) and C(n-2) are the two previously produced ciphertext words.
- R5: A word is accepted only in a cycle where pt_valid, smp_valid and output space are all present. In any other cycle both histories are left unchanged, and no ciphertext word is produced one cycle later.
- R6: ct_valid goes to 1 in the cycle after an accept. While ct_valid is 1 and ct_ready is 0, ct_valid and ct_data hold their values.
- R7: pt_ready is 1 only when smp_valid is 1, and smp_ready is 1 only when pt_valid is 1. Both are 1 exactly when the other stream is valid and either ct_valid is 0 or ct_ready is 1.
- R8: When ct_ready is 1, a new word is accepted in the same cycle that the held word drains, so one word per cycle is sustained.
- R9: Running the same sample stream from reset through P(n) = C(n) XOR z(n) XOR Fb(n) recovers every plaintext word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_valid | input | 1 | Plaintext word present |
| pt_ready | output | 1 | Plaintext word taken this cycle |
| pt_data | input | 16 | Plaintext word |
| smp_valid | input | 1 | Chaotic sample present |
| smp_ready | output | 1 | Sample taken this cycle |
| smp_word | input | 16 | Low 16 bits of the chaotic state |
| smp_sel | input | 1 | Top bit of the chaotic state; selects the feedback age |
| ct_valid | output | 1 | Ciphertext word present |
| ct_ready | input | 1 | Downstream takes the ciphertext word |
| ct_data | output | 16 | Ciphertext word |

## Verification
Two things can happen in the same cycle: the held ciphertext word drains, and a new word is accepted and computed from histories that are advancing in that same cycle. The bench provokes this by first stalling the output with ct_ready low while both inputs stay valid, and checking that nothing is accepted and the held word stays stable. It then raises ct_ready and checks two things. The ready signals must rise in that same cycle. On the next cycle the output must carry the new word, computed with the stalled word counted as C(n-1) exactly once. A stream of back-to-back words is also checked against a bench model and decrypted again to confirm that no history step is lost or repeated.

// File: rtl/kmask_pkg.sv
package kmask_pkg;
  // meaning of the feedback select bit
  typedef enum logic {
    FB_PREV  = 1'b0,
    FB_OLDER = 1'b1
  } fb_sel_e;
endpackage

// File: rtl/kmask_sample_hist.sv
module kmask_sample_hist #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] z_out
);
  logic [W-1:0] hist_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     hist_q[i] <= '0;
        else if (shift) hist_q[i] <= y_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)     hist_q[i] <= '0;
        else if (shift) hist_q[i] <= hist_q[i-1];
      end
    end
  end

  always_comb begin
    z_out = y_in;
    for (int k = 0; k < DEPTH; k++) z_out = z_out ^ hist_q[k];
  end
endmodule

// File: rtl/kmask_ct_hist.sv
module kmask_ct_hist
  import kmask_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] c_in,
  input  fb_sel_e      sel,
  output logic [W-1:0] fb_out
);
  logic [W-1:0] hist_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     hist_q[i] <= '0;
        else if (shift) hist_q[i] <= c_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)     hist_q[i] <= '0;
        else if (shift) hist_q[i] <= hist_q[i-1];
      end
    end
  end

  always_comb begin
    unique case (sel)
      FB_OLDER: fb_out = hist_q[DEPTH-1];
      default:  fb_out = hist_q[0];
    endcase
  end
endmodule

// File: rtl/kmask_out_stage.sv
module kmask_out_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_in,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= d_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/keystream_masker.sv
module keystream_masker
  import kmask_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned SMP_TAPS = 3,
  parameter int unsigned FB_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pt_valid,
  output logic              pt_ready,
  input  logic [WORD_W-1:0] pt_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [WORD_W-1:0] smp_word,
  input  logic              smp_sel,
  output logic              ct_valid,
  input  logic              ct_ready,
  output logic [WORD_W-1:0] ct_data
);
  localparam int unsigned SMP_HIST = SMP_TAPS - 1;

  logic              slot_free;
  logic              accept;
  logic [WORD_W-1:0] z_word;
  logic [WORD_W-1:0] fb_word;
  logic [WORD_W-1:0] c_word;
  fb_sel_e           sel_e;

  assign pt_ready  = smp_valid && slot_free;
  assign smp_ready = pt_valid && slot_free;
  assign accept    = pt_valid && smp_valid && slot_free;
  assign sel_e     = fb_sel_e'(smp_sel);
  assign c_word    = pt_data ^ z_word ^ fb_word;

  kmask_sample_hist #(.W(WORD_W), .DEPTH(SMP_HIST)) u_smp (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (accept),
    .y_in  (smp_word),
    .z_out (z_word)
  );

  kmask_ct_hist #(.W(WORD_W), .DEPTH(FB_DEPTH)) u_cth (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (accept),
    .c_in   (c_word),
    .sel    (sel_e),
    .fb_out (fb_word)
  );

  kmask_out_stage #(.W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .d_in      (c_word),
    .out_ready (ct_ready),
    .out_valid (ct_valid),
    .out_data  (ct_data),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/kmask_checker.sv
module kmask_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pt_valid,
  input logic         pt_ready,
  input logic         smp_valid,
  input logic         smp_ready,
  input logic         ct_valid,
  input logic         ct_ready,
  input logic [W-1:0] ct_data
);
  logic fire;
  assign fire = pt_valid && pt_ready && smp_valid && smp_ready;

  AST_PT_READY_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    pt_ready |-> smp_valid); // R7
  AST_SMP_READY_JOIN: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> pt_valid); // R7
  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ct_valid); // R6
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && !ct_ready) |=> (ct_valid && $stable(ct_data))); // R6
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && (ct_ready || !ct_valid)) |=> !ct_valid); // R5
  AST_DRAIN_AND_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && ct_ready && pt_valid && smp_valid) |-> (pt_ready && smp_ready)); // R8
endmodule

bind keystream_masker kmask_checker #(.W(WORD_W)) u_kmask_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pt_valid  (pt_valid),
  .pt_ready  (pt_ready),
  .smp_valid (smp_valid),
  .smp_ready (smp_ready),
  .ct_valid  (ct_valid),
  .ct_ready  (ct_ready),
  .ct_data   (ct_data)
);

// File: tb/keystream_masker_bench.sv
module keystream_masker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pt_valid, smp_valid, smp_sel, ct_ready;
  logic        pt_ready, smp_ready, ct_valid;
  logic [15:0] pt_data, smp_word, ct_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  keystream_masker u_keystream_masker (
    .clk(clk), .rst_n(rst_n),
    .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_data(pt_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_word(smp_word), .smp_sel(smp_sel),
    .ct_valid(ct_valid), .ct_ready(ct_ready), .ct_data(ct_data)
  );

  // {plaintext, sample, select, expected ciphertext}, histories zero at start
  localparam logic [48:0] VEC [6] = '{
    {16'h1234, 16'h00F0, 1'b0, 16'h12C4},
    {16'h0000, 16'h0F00, 1'b1, 16'h0FF0},
    {16'hFFFF, 16'hF000, 1'b0, 16'h0FFF},
    {16'hA5A5, 16'h0000, 1'b1, 16'h5555},
    {16'h0001, 16'h0001, 1'b0, 16'hA555},
    {16'h8000, 16'h8000, 1'b1, 16'h5554}
  };

  // encrypt-side model and separate decrypt-side model
  logic [15:0] e_y1, e_y2, e_c1, e_c2;
  logic [15:0] d_y1, d_y2, d_c1, d_c2;

  task automatic model_reset();
    e_y1 = 0; e_y2 = 0; e_c1 = 0; e_c2 = 0;
    d_y1 = 0; d_y2 = 0; d_c1 = 0; d_c2 = 0;
  endtask

  function automatic logic [15:0] model_enc(input logic [15:0] p, input logic [15:0] y, input logic s);
    logic [15:0] c;
    c = p ^ y ^ e_y1 ^ e_y2 ^ (s ? e_c2 : e_c1);
    e_y2 = e_y1; e_y1 = y; e_c2 = e_c1; e_c1 = c;
    return c;
  endfunction

  function automatic logic [15:0] model_dec(input logic [15:0] c, input logic [15:0] y, input logic s);
    logic [15:0] p;
    p = c ^ y ^ d_y1 ^ d_y2 ^ (s ? d_c2 : d_c1);
    d_y2 = d_y1; d_y1 = y; d_c2 = d_c1; d_c1 = c;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    pt_valid = 0; smp_valid = 0; ct_ready = 1; smp_sel = 0;
    pt_data = 0; smp_word = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  // called at a negedge: present a word, check it one cycle later
  task automatic step(input logic [15:0] p, input logic [15:0] y, input logic s, input string req);
    logic [15:0] exp_c;
    pt_data = p; smp_word = y; smp_sel = s; pt_valid = 1; smp_valid = 1;
    exp_c = model_enc(p, y, s);
    @(negedge clk);
    check(ct_valid === 1'b1, req, {31'd0, ct_valid}, 32'd1);
    check(ct_data === exp_c, req, {16'd0, ct_data}, {16'd0, exp_c});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] lfsr;
    logic [15:0] held;
    logic [15:0] exp_c;
    do_reset();

    // R1: reset state
    check(ct_valid === 1'b0, "R1 reset valid", {31'd0, ct_valid}, 0);
    check(pt_ready === 1'b0, "R7 ready without sample", {31'd0, pt_ready}, 0);

    // R2 R3 R4: table walk
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      logic [15:0] exp_t;
      pt_data = VEC[i][48:33]; smp_word = VEC[i][32:17]; smp_sel = VEC[i][16];
      exp_t = VEC[i][15:0];
      pt_valid = 1; smp_valid = 1;
      void'(model_enc(pt_data, smp_word, smp_sel));
      @(negedge clk);
      check(ct_data === exp_t, "R3 R4 table", {16'd0, ct_data}, {16'd0, exp_t});
    end
    pt_valid = 0; smp_valid = 0;
    @(negedge clk);
    check(ct_valid === 1'b0, "R5 no word without input", {31'd0, ct_valid}, 0);

    // R5: one-sided valid must not move histories
    pt_valid = 1; pt_data = 16'hDEAD; smp_valid = 0;
    #1 check(smp_ready === 1'b1 && pt_ready === 1'b0, "R7 one side", {30'd0, smp_ready, pt_ready}, 32'd2);
    repeat (3) @(negedge clk);
    check(ct_valid === 1'b0, "R5 pt only", {31'd0, ct_valid}, 0);
    pt_valid = 0; smp_valid = 1; smp_word = 16'hBEEF;
    repeat (3) @(negedge clk);
    check(ct_valid === 1'b0, "R5 smp only", {31'd0, ct_valid}, 0);
    step(16'h0F0F, 16'h3C3C, 1'b0, "R5 history unchanged");
    step(16'h1111, 16'h2222, 1'b1, "R2 after idle");
    pt_valid = 0; smp_valid = 0;
    @(negedge clk);

    // R6 R8: stall then drain and accept in the same cycle
    ct_ready = 0;
    step(16'h7777, 16'h0101, 1'b0, "R6 load");
    held = ct_data;
    pt_data = 16'h5A5A; smp_word = 16'h6006; smp_sel = 0;
    #1 check(pt_ready === 1'b0 && smp_ready === 1'b0, "R7 stalled", {30'd0, pt_ready, smp_ready}, 0);
    repeat (3) begin
      @(negedge clk);
      check(ct_valid === 1'b1 && ct_data === held, "R6 hold", {16'd0, ct_data}, {16'd0, held});
    end
    ct_ready = 1;
    #1 check(pt_ready === 1'b1 && smp_ready === 1'b1, "R8 same-cycle take", {30'd0, pt_ready, smp_ready}, 32'd3);
    exp_c = model_enc(16'h5A5A, 16'h6006, 1'b0);
    @(negedge clk);
    check(ct_valid === 1'b1 && ct_data === exp_c, "R8 new word", {16'd0, ct_data}, {16'd0, exp_c});
    pt_valid = 0; smp_valid = 0;
    @(negedge clk);
    check(ct_valid === 1'b0, "R6 drained", {31'd0, ct_valid}, 0);

    // R1: zero history after reset, select 1
    do_reset();
    @(negedge clk);
    pt_data = 16'hC3C3; smp_word = 16'h0FF0; smp_sel = 1; pt_valid = 1; smp_valid = 1;
    @(negedge clk);
    check(ct_data === 16'hCC33, "R1 first word", {16'd0, ct_data}, 32'h0000CC33);
    pt_valid = 0; smp_valid = 0;

    // R9: back-to-back stream with round trip
    do_reset();
    @(negedge clk);
    lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      logic [15:0] p, y, c, back;
      logic s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p = lfsr ^ 16'h9C3A; y = {lfsr[7:0], lfsr[15:8]}; s = lfsr[3];
      pt_data = p; smp_word = y; smp_sel = s; pt_valid = 1; smp_valid = 1;
      c = model_enc(p, y, s);
      @(negedge clk);
      check(ct_valid === 1'b1 && ct_data === c, "R2 R3 stream", {16'd0, ct_data}, {16'd0, c});
      back = model_dec(ct_data, y, s);
      check(back === p, "R9 round trip", {16'd0, back}, {16'd0, p});
    end
    pt_valid = 0; smp_valid = 0;
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule